// File: doc/BRIEF.md
# Timed Periodic Pulse Output Generator

This block drives up to four pulse outputs that are locked to a free-running seconds/nanoseconds time counter, which it receives as an input. Each output has its own set of registers: a target start time, a period and a high width. Software programs these registers over a simple 32-bit register port. It then writes a start or stop command into a shared control register, where each output has its own packed field.

A started output waits until the time counter reaches its target. From that point it produces a repeating train of pulses. The period and the width are counted in time-counter increment strobes, not in bus clocks, so the edges stay aligned with the counter. Each channel also has a busy flag that guards the target time while an arm is pending. A global enable bit selects the flexible mode. When that bit is clear, every channel is held idle and output 0 shows a fixed half-second square wave taken from the nanoseconds count.

Top module: `pulse_train_gen`

## Requirements
- R1: After reset, the control register reads 0, every busy flag reads 0, and outputs 1 and above are low.
- R2: The control register is at byte address 0x00. Channel n's registers are at 0x10*(n+1): +0x0 target seconds, +0x4 target nanoseconds (bits [30:0]), +0x8 interval, +0xC width. Each reads back what was written. In the control register, the mode bits [8n+6:8n+5] and the enable bit 4 read back as written, and the command bits read as 0.
- R3: Bit 31 of the target-nanoseconds register is a read-only busy flag. It sets when that register is written. It clears on the clock edge at which {time seconds, time nanoseconds} is greater than or equal to {target seconds, target nanoseconds}, with the seconds field compared first.
- R4: While a channel's busy flag is set, writes to any of that channel's four registers are ignored.
- R5: A control write arms channel n when all three of these hold: field bits [8n+3:8n] = 0x2, mode bits [8n+6:8n+5] = 2, and bit 4 = 1. An armed output rises at the first clock edge at which the time counter has reached the target, and stays low before that edge.
- R6: A running output is high for width+1 tick strobes and low for interval-width tick strobes, so the period is interval+1 strobes. The train repeats.
- R7: Field code 0x5 stops a channel. A running train finishes its current period and then idles low. An armed channel that is stopped never starts.
- R8: A start is ignored when the interval or the width register is 0, or when the mode bits are not 2.
- R9: While bit 4 is clear, every channel is idle and outputs 1 and above are low. Output 0 is then high exactly when time nanoseconds < FIXED_HIGH_NS. A channel halted this way does not restart when bit 4 is set again.
- R10: The channels run independently. The interval and width are captured at start, so writing new values while a train runs does not change that train.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| tc_sec | input | 32 | Time counter seconds |
| tc_nsec | input | 32 | Time counter nanoseconds |
| tc_tick | input | 1 | One-cycle strobe for each time-counter increment |
| pulse_out | output | NUM_OUT | Pulse outputs |

## Verification
A write lands on the clock edge that samples it. Readback and busy are combinational, so the bench drives each write at a falling edge and reads after the following falling edge. An output rises on the same rising edge at which the time value applied from the previous falling edge reaches the target. The bench therefore steps the frozen time to target-1 and then to the target, and samples the output at the falling edge between these steps. Widths and periods are measured by counting tick strobes rather than clock cycles. At each falling edge the bench records the output level and the strobe it is about to apply, and it counts from one rising output edge to the next.

// File: rtl/ppg_pkg.sv
`timescale 1ns/1ps
package ppg_pkg;
  localparam int REG_W = 32;
  localparam int NS_W  = 31;

  localparam logic [3:0] CMD_START  = 4'h2;
  localparam logic [3:0] CMD_STOP   = 4'h5;
  localparam logic [1:0] MODE_PULSE = 2'd2;

  typedef enum logic [1:0] {CH_IDLE, CH_ARMED, CH_RUN} ch_state_e;

  // time has reached target: seconds field is the more significant part
  function automatic logic time_reached(input logic [REG_W-1:0] now_s,
                                        input logic [REG_W-1:0] now_ns,
                                        input logic [REG_W-1:0] tgt_s,
                                        input logic [NS_W-1:0]  tgt_ns);
    return {now_s, now_ns} >= {tgt_s, 1'b0, tgt_ns};
  endfunction

  function automatic logic params_valid(input logic [REG_W-1:0] intv,
                                        input logic [REG_W-1:0] wid);
    return (intv != '0) && (wid != '0);
  endfunction

  function automatic logic in_high_phase(input logic [REG_W-1:0] cnt,
                                         input logic [REG_W-1:0] wid);
    return cnt <= wid;
  endfunction

  function automatic logic last_tick(input logic [REG_W-1:0] cnt,
                                     input logic [REG_W-1:0] intv);
    return cnt == intv;
  endfunction
endpackage

// File: rtl/ppg_ctrl.sv
`timescale 1ns/1ps
module ppg_ctrl
  import ppg_pkg::*;
#(
  parameter int NUM_OUT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_wr,
  input  logic [REG_W-1:0]   wdata,
  output logic               flex_live,
  output logic               flex_q,
  output logic [NUM_OUT-1:0] start_req,
  output logic [NUM_OUT-1:0] stop_req,
  output logic [REG_W-1:0]   ctrl_rd
);
  localparam int FLD_W  = 8;
  localparam int EN_BIT = 4;

  logic [1:0] mode_q [NUM_OUT];
  logic       unused_ctrl;

  assign unused_ctrl = ^wdata;
  assign flex_live   = ctrl_wr ? wdata[EN_BIT] : flex_q;

  for (genvar n = 0; n < NUM_OUT; n++) begin : g_fld
    logic [3:0] code;
    logic [1:0] mode;
    assign code = wdata[FLD_W*n +: 4];
    assign mode = wdata[FLD_W*n+5 +: 2];
    assign start_req[n] = ctrl_wr && wdata[EN_BIT] && (code == CMD_START) && (mode == MODE_PULSE);
    assign stop_req[n]  = ctrl_wr && (code == CMD_STOP);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q[n] <= '0;
      else if (ctrl_wr) mode_q[n] <= mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flex_q <= 1'b0;
    else if (ctrl_wr) flex_q <= wdata[EN_BIT];
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[EN_BIT] = flex_q;
    for (int n = 0; n < NUM_OUT; n++) ctrl_rd[FLD_W*n+5 +: 2] = mode_q[n];
  end

  // R5: a start and a stop never reach the same channel together
  a_r5_cmd_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req & stop_req) == '0);
endmodule

// File: rtl/ppg_channel.sv
`timescale 1ns/1ps
module ppg_channel
  import ppg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_off,
  input  logic [REG_W-1:0] wdata,
  input  logic [1:0]       rd_off,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             flex_en,
  input  logic [REG_W-1:0] tc_sec,
  input  logic [REG_W-1:0] tc_nsec,
  input  logic             tc_tick,
  output logic [REG_W-1:0] rd_data,
  output logic             pulse
);
  logic [REG_W-1:0] tsec_q, intv_q, wid_q, act_intv, act_wid, cnt_q;
  logic [NS_W-1:0]  tnsec_q;
  logic             busy_q, stop_pend;
  ch_state_e        st_q;

  // named internal events
  logic reached, wr_acc, nsec_wr, start_ok, run_tick, period_end;
  assign reached    = time_reached(tc_sec, tc_nsec, tsec_q, tnsec_q);
  assign wr_acc     = wr_en && !busy_q;
  assign nsec_wr    = wr_acc && (wr_off == 2'd1);
  assign start_ok   = start_req && (st_q == CH_IDLE) && params_valid(intv_q, wid_q);
  assign run_tick   = (st_q == CH_RUN) && tc_tick;
  assign period_end = run_tick && last_tick(cnt_q, act_intv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsec_q  <= '0;
      tnsec_q <= '0;
      intv_q  <= '0;
      wid_q   <= '0;
      busy_q  <= 1'b0;
    end else begin
      if (wr_acc) begin
        case (wr_off)
          2'd0:    tsec_q  <= wdata;
          2'd1:    tnsec_q <= wdata[NS_W-1:0];
          2'd2:    intv_q  <= wdata;
          default: wid_q   <= wdata;
        endcase
      end
      if (busy_q && reached) busy_q <= 1'b0;
      else if (nsec_wr)      busy_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= CH_IDLE;
      cnt_q     <= '0;
      act_intv  <= '0;
      act_wid   <= '0;
      stop_pend <= 1'b0;
    end else if (!flex_en) begin
      st_q      <= CH_IDLE;
      stop_pend <= 1'b0;
    end else begin
      case (st_q)
        CH_IDLE: if (start_ok) begin
          st_q     <= CH_ARMED;
          act_intv <= intv_q;
          act_wid  <= wid_q;
        end
        CH_ARMED: if (stop_req) st_q <= CH_IDLE;
          else if (reached) begin
            st_q  <= CH_RUN;
            cnt_q <= '0;
          end
        default: begin
          if (stop_req) stop_pend <= 1'b1;
          if (period_end) begin
            cnt_q <= '0;
            if (stop_pend || stop_req) begin
              st_q      <= CH_IDLE;
              stop_pend <= 1'b0;
            end
          end else if (run_tick) cnt_q <= cnt_q + 1'b1;
        end
      endcase
    end
  end

  assign pulse = (st_q == CH_RUN) && in_high_phase(cnt_q, act_wid);

  always_comb begin
    case (rd_off)
      2'd0:    rd_data = tsec_q;
      2'd1:    rd_data = {busy_q, tnsec_q};
      2'd2:    rd_data = intv_q;
      default: rd_data = wid_q;
    endcase
  end

  a_r3_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(wr_en && (wr_off == 2'd1)));
  a_r3_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && reached) |=> !busy_q);
  a_r4_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wr_en) |=> ($stable(tsec_q) && $stable(tnsec_q) && $stable(intv_q) && $stable(wid_q)));
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CH_RUN) |-> (cnt_q <= act_intv));
  a_r7_run_to_end: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == CH_RUN) && flex_en && !period_end) |=> (st_q == CH_RUN));
  a_r8_invalid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == CH_IDLE) && ((intv_q == '0) || (wid_q == '0))) |=> (st_q == CH_IDLE));
  a_r9_flex_off: assert property (@(posedge clk) disable iff (!rst_n)
    !flex_en |=> (st_q == CH_IDLE));
endmodule

// File: rtl/pulse_train_gen.sv
`timescale 1ns/1ps
module pulse_train_gen
  import ppg_pkg::*;
#(
  parameter int          NUM_OUT       = 4,
  parameter int          ADDR_W        = 8,
  parameter logic [31:0] FIXED_HIGH_NS = 32'd500_000_000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  input  logic [REG_W-1:0]   tc_sec,
  input  logic [REG_W-1:0]   tc_nsec,
  input  logic               tc_tick,
  output logic [NUM_OUT-1:0] pulse_out
);
  localparam int PAGE_W = ADDR_W - 4;

  logic [PAGE_W-1:0]  page;
  logic [1:0]         word;
  logic               ctrl_wr, flex_live, flex_q, unused_addr;
  logic [NUM_OUT-1:0] start_req, stop_req, ch_pulse;
  logic [REG_W-1:0]   ctrl_rd;
  logic [REG_W-1:0]   ch_rd [NUM_OUT];

  assign page        = bus_addr[ADDR_W-1:4];
  assign word        = bus_addr[3:2];
  assign unused_addr = ^bus_addr[1:0];
  assign ctrl_wr     = bus_wr && (page == '0) && (word == 2'd0);

  ppg_ctrl #(.NUM_OUT(NUM_OUT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wdata(bus_wdata),
    .flex_live(flex_live), .flex_q(flex_q),
    .start_req(start_req), .stop_req(stop_req), .ctrl_rd(ctrl_rd)
  );

  for (genvar n = 0; n < NUM_OUT; n++) begin : g_ch
    logic ch_wr;
    assign ch_wr = bus_wr && (page == PAGE_W'(n + 1));
    ppg_channel u_ch (
      .clk(clk), .rst_n(rst_n), .wr_en(ch_wr), .wr_off(word), .wdata(bus_wdata),
      .rd_off(word), .start_req(start_req[n]), .stop_req(stop_req[n]),
      .flex_en(flex_live), .tc_sec(tc_sec), .tc_nsec(tc_nsec), .tc_tick(tc_tick),
      .rd_data(ch_rd[n]), .pulse(ch_pulse[n])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if ((page == '0) && (word == 2'd0)) bus_rdata = ctrl_rd;
    for (int n = 0; n < NUM_OUT; n++)
      if (page == PAGE_W'(n + 1)) bus_rdata = ch_rd[n];
  end

  always_comb begin
    pulse_out    = ch_pulse;
    pulse_out[0] = flex_q ? ch_pulse[0] : (tc_nsec < FIXED_HIGH_NS);
  end

  // R9: with the enable clear only output 0 may be active
  a_r9_fixed_only0: assert property (@(posedge clk) disable iff (!rst_n)
    !flex_q |-> ((pulse_out >> 1) == '0));
endmodule

// File: tb/pulse_train_gen_test.sv
`timescale 1ns/1ps
module pulse_train_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] tc_sec = 32'd5, tc_nsec = '0;
  logic        tc_tick = 1'b0;
  logic [3:0]  pulse_out;

  pulse_train_gen uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tc_sec(tc_sec),
    .tc_nsec(tc_nsec), .tc_tick(tc_tick), .pulse_out(pulse_out)
  );

  always #4 clk = ~clk;

  // channel, interval, width
  localparam int VEC [5][3] = '{'{0, 4, 1}, '{1, 9, 4}, '{2, 5, 3}, '{3, 7, 1}, '{0, 3, 2}};

  int checks = 0, fails = 0, tick_div = 0;
  logic [31:0] ts = 32'd5, tn = '0;
  logic time_run = 1'b1;
  logic [3:0] s_pulse = '0;
  logic s_tick = 1'b0;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_time(input logic [31:0] s, input logic [31:0] n);
    ts = s; tn = n; tc_sec = s; tc_nsec = n;
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    s_pulse = pulse_out;
    if (time_run && tc_tick) begin
      tn = tn + 32'd10;
      if (tn >= 32'd1_000_000_000) begin tn = tn - 32'd1_000_000_000; ts = ts + 1; end
      tc_sec = ts; tc_nsec = tn;
    end
    tick_div = (tick_div == 2) ? 0 : tick_div + 1;
    tc_tick = (tick_div == 0);
    s_tick = tc_tick;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    cyc();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [7:0] base(input int ch);
    return 8'(16 * (ch + 1));
  endfunction

  function automatic logic [31:0] start_word(input int ch, input logic [1:0] mode);
    return 32'h10 | ((32'h2 | (32'(mode) << 5)) << (8 * ch));
  endfunction

  task automatic prog(input int ch, input logic [31:0] s, input logic [31:0] n,
                      input logic [31:0] intv, input logic [31:0] wid);
    wr(base(ch) + 8'h8, intv);
    wr(base(ch) + 8'hC, wid);
    wr(base(ch) + 8'h0, s);
    wr(base(ch) + 8'h4, n);
  endtask

  task automatic watch(input int ch, input int n, output int rises);
    rises = 0;
    for (int k = 0; k < n; k++) begin
      logic prev;
      prev = s_pulse[ch];
      cyc();
      if (!prev && s_pulse[ch]) rises++;
    end
  endtask

  task automatic measure(input int ch, output int hi, output int lo);
    logic found, done;
    found = 1'b0; done = 1'b0; hi = 0; lo = 0;
    for (int k = 0; k < 3000 && !found; k++) begin
      logic prev;
      prev = s_pulse[ch];
      cyc();
      if (!prev && s_pulse[ch]) found = 1'b1;
    end
    for (int k = 0; k < 3000 && !done; k++) begin
      logic prev;
      if (s_tick) begin if (s_pulse[ch]) hi++; else lo++; end
      prev = s_pulse[ch];
      cyc();
      if (!prev && s_pulse[ch]) done = 1'b1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: all requirements actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d, tgt;
    int hi, lo, rises;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();

    // R1 reset state
    rd(8'h00, d); check("R1 ctrl after reset", d, 32'h0);
    for (int ch = 0; ch < 4; ch++) begin
      rd(base(ch) + 8'h4, d); check("R1 busy after reset", {31'b0, d[31]}, 32'h0);
    end
    check("R1 outputs 1..3 low", {29'b0, pulse_out[3:1]}, 32'h0);
    check("R9 fixed out0 high in first half second", {31'b0, pulse_out[0]}, 32'h1);

    // R2 readback, R3 busy, R4 lock
    prog(2, 32'h77, 32'h100, 32'h1234, 32'h56);
    rd(base(2) + 8'h8, d); check("R2 interval readback", d, 32'h1234);
    rd(base(2) + 8'hC, d); check("R2 width readback", d, 32'h56);
    rd(base(2) + 8'h0, d); check("R2 seconds readback", d, 32'h77);
    rd(base(2) + 8'h4, d); check("R3 nsec readback with busy", d, 32'h8000_0100);
    wr(base(2) + 8'h8, 32'h9);
    rd(base(2) + 8'h8, d); check("R4 interval write ignored while busy", d, 32'h1234);
    wr(base(2) + 8'h0, 32'h1);
    rd(base(2) + 8'h0, d); check("R4 seconds write ignored while busy", d, 32'h77);
    time_run = 1'b0;
    set_time(32'h76, 32'h3B9A_C9F0); cyc();
    rd(base(2) + 8'h4, d); check("R3 busy held: larger nsec smaller sec", {31'b0, d[31]}, 32'h1);
    set_time(32'h77, 32'hFF); cyc();
    rd(base(2) + 8'h4, d); check("R3 busy held one below target", {31'b0, d[31]}, 32'h1);
    set_time(32'h77, 32'h100); cyc();
    rd(base(2) + 8'h4, d); check("R3 busy cleared at target", {31'b0, d[31]}, 32'h0);

    // R5 exact start edge (time frozen)
    tgt = tn + 32'd200;
    prog(1, ts, tgt, 32'd5, 32'd2);
    wr(8'h00, start_word(1, 2'd2));
    repeat (4) cyc();
    check("R5 low before target", {31'b0, s_pulse[1]}, 32'h0);
    set_time(ts, tgt - 1); cyc();
    check("R5 low one below target", {31'b0, s_pulse[1]}, 32'h0);
    set_time(ts, tgt); cyc();
    check("R5 high at target edge", {31'b0, s_pulse[1]}, 32'h1);
    rd(base(1) + 8'h4, d); check("R3 busy clear at start", {31'b0, d[31]}, 32'h0);
    rd(8'h00, d); check("R2 ctrl readback mode and enable", d, 32'h0000_4010);
    time_run = 1'b1;
    wr(8'h00, 32'h10 | (32'h5 << 8));
    repeat (40) cyc();
    check("R7 stopped channel low", {31'b0, s_pulse[1]}, 32'h0);

    // R6/R7 vector table
    for (int v = 0; v < 5; v++) begin
      int ch, iv, wd;
      ch = VEC[v][0]; iv = VEC[v][1]; wd = VEC[v][2];
      prog(ch, ts, tn + 32'd60, 32'(iv), 32'(wd));
      wr(8'h00, start_word(ch, 2'd2));
      measure(ch, hi, lo);
      check("R6 high ticks", 32'(hi), 32'(wd + 1));
      check("R6 low ticks", 32'(lo), 32'(iv - wd));
      wr(8'h00, 32'h10 | (32'h5 << (8 * ch)));
      repeat (3 * (iv + 2) + 6) cyc();
      check("R7 low after stop", {31'b0, s_pulse[ch]}, 32'h0);
      watch(ch, 3 * (iv + 2), rises);
      check("R7 no pulses after stop", 32'(rises), 32'h0);
    end

    // R7 stop in the middle of a high phase
    prog(1, ts, tn + 32'd60, 32'd9, 32'd6);
    wr(8'h00, start_word(1, 2'd2));
    for (int k = 0; k < 500 && !s_pulse[1]; k++) cyc();
    repeat (3) cyc();
    wr(8'h00, 32'h10 | (32'h5 << 8));
    check("R7 period continues after stop", {31'b0, s_pulse[1]}, 32'h1);
    watch(1, 120, rises);
    check("R7 no new period after stop", 32'(rises), 32'h0);
    check("R7 idle low at end", {31'b0, s_pulse[1]}, 32'h0);

    // R7 stop while armed
    prog(3, ts, tn + 32'd600, 32'd4, 32'd1);
    wr(8'h00, start_word(3, 2'd2));
    cyc();
    wr(8'h00, 32'h10 | (32'h5 << 24));
    watch(3, 300, rises);
    check("R7 armed stop never starts", 32'(rises), 32'h0);

    // R8 invalid starts
    prog(2, ts, tn + 32'd30, 32'd0, 32'd3);
    wr(8'h00, start_word(2, 2'd2));
    watch(2, 150, rises);
    check("R8 zero interval ignored", 32'(rises), 32'h0);
    prog(2, ts, tn + 32'd30, 32'd5, 32'd0);
    wr(8'h00, start_word(2, 2'd2));
    watch(2, 150, rises);
    check("R8 zero width ignored", 32'(rises), 32'h0);
    prog(2, ts, tn + 32'd30, 32'd5, 32'd2);
    wr(8'h00, start_word(2, 2'd1));
    rd(8'h00, d); check("R2 ctrl mode field readback", d, 32'h0020_0010);
    watch(2, 150, rises);
    check("R8 mode 1 ignored", 32'(rises), 32'h0);

    // R10 two channels, capture at start
    prog(0, ts, tn + 32'd60, 32'd7, 32'd3);
    prog(2, ts, tn + 32'd60, 32'd4, 32'd1);
    wr(8'h00, start_word(0, 2'd2) | start_word(2, 2'd2));
    measure(0, hi, lo);
    check("R10 ch0 high ticks", 32'(hi), 32'd4);
    check("R10 ch0 low ticks", 32'(lo), 32'd4);
    wr(base(0) + 8'h8, 32'd20);
    rd(base(0) + 8'h8, d); check("R2 interval write while running", d, 32'd20);
    measure(0, hi, lo);
    check("R10 ch0 period unchanged by write", 32'(hi + lo), 32'd8);
    measure(2, hi, lo);
    check("R10 ch2 high ticks", 32'(hi), 32'd2);
    check("R10 ch2 low ticks", 32'(lo), 32'd3);

    // R9 enable cleared
    wr(8'h00, 32'h0);
    check("R9 outputs 1..3 low with enable clear", {29'b0, s_pulse[3:1]}, 32'h0);
    time_run = 1'b0;
    set_time(ts, 32'd100); cyc();
    check("R9 fixed out0 high below threshold", {31'b0, s_pulse[0]}, 32'h1);
    set_time(ts, 32'd600_000_000); cyc();
    check("R9 fixed out0 low above threshold", {31'b0, s_pulse[0]}, 32'h0);
    wr(8'h00, 32'h10);
    time_run = 1'b1;
    watch(0, 60, rises);
    check("R9 no restart after re-enable", {28'b0, s_pulse}, 32'h0);
    check("R9 no rising edge after re-enable", 32'(rises), 32'h0);

    summary();
    $finish;
  end
endmodule